// File: doc/BRIEF.md
# Weighted Context Slot Scheduler

This block decides which of 16 hardware register-set contexts owns the pipeline. It holds a table of 256 slots, and each slot names a context by a 4-bit ID. A slot pointer moves through the table. The entry under the pointer becomes the context-ID output one cycle later. A context that fills more slots runs more often. Priority is therefore set by how slots are shared out, not by a separate priority field.

The pointer moves in one of two modes, chosen by `autoMode`:
- **Automatic mode:** the pointer steps once for every cycle in which `advEn` is high.
- **Manual mode:** the pointer steps only when software issues a `stepReq` command, for example from a periodic service routine.

Software fills and inspects the table through a write port and a read port, each indexed by slot number. Reset clears every slot, so context 0 is the only one that runs until the table is loaded. Slot 0 is wired to context 0 for good. This guarantees that context 0 always gets at least one turn per lap of the table.

Top module: `ctx_slot_sched`

## Requirements
- R1: While `rstN` is low and after it is released, `slotPtr` and `ctxId` are 0 and every slot reads back as context 0.
- R2: A write with `wrEn` high to slot s (s not 0) stores `wrCtx`. From the next cycle on, `rdCtx` returns that value whenever `rdSlot` is s. The read port is combinational.
- R3: Writes to slot 0 have no effect, and `rdCtx` is 0 whenever `rdSlot` is 0.
- R4: When `autoMode` is 1, `slotPtr` rises by one after each clock edge at which `advEn` is 1. It holds when `advEn` is 0. `stepReq` is ignored in this mode.
- R5: When `autoMode` is 0, `slotPtr` rises by one only after an edge at which `stepReq` is 1. `advEn` is ignored in this mode.
- R6: The 8-bit pointer wraps from 255 to 0.
- R7: `ctxId` after a clock edge equals the table entry that the pointer addressed just before that edge. The output therefore lags a pointer change by one cycle.
- R8: Over any 256 consecutive automatic steps, each context ID appears on `ctxId` exactly as many times as slots hold it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| autoMode | input | 1 | 1: pointer self-advances; 0: pointer steps on command |
| advEn | input | 1 | Advance enable used in automatic mode |
| stepReq | input | 1 | Single-step command used in manual mode |
| wrEn | input | 1 | Table write strobe |
| wrSlot | input | 8 | Slot index to write |
| wrCtx | input | 4 | Context ID to store |
| rdSlot | input | 8 | Slot index to read |
| rdCtx | output | 4 | Context ID stored at `rdSlot` (combinational) |
| ctxId | output | 4 | Context selected to run (registered) |
| slotPtr | output | 8 | Current slot pointer |

## Verification
A step or write command presented before edge k shows up in different places at different times:
- `slotPtr` and the read port reflect it just after edge k.
- `ctxId` shows the entry for the new pointer only after edge k+1.

The bench drives inputs on the falling edge and samples on the next falling edge. Its cycle model applies the same order at every rising edge: first the old-table lookup for `ctxId`, then the pointer step, then the table write. Each sample is therefore compared with the value due in exactly that cycle.

// File: rtl/ctx_sched_pkg.sv
package ctx_sched_pkg;
  // Strobes issued by the control to the datapath each cycle.
  typedef struct packed {
    logic ptrStep;   // pointer advances at this edge
    logic tblWrite;  // table entry is written at this edge
  } schedStrobe_t;
endpackage

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import ctx_sched_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             autoMode,
  input  logic             advEn,
  input  logic             stepReq,
  input  logic             wrEn,
  input  logic [PTR_W-1:0] wrSlot,
  output schedStrobe_t     strobe,
  output logic [PTR_W-1:0] slotPtr
);
  logic [PTR_W-1:0] ptrQ;

  always_comb begin
    strobe.ptrStep  = autoMode ? advEn : stepReq;
    strobe.tblWrite = wrEn && (wrSlot != '0);
  end

  // Pointer wraps naturally at 2**PTR_W.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ptrQ <= '0;
    else if (strobe.ptrStep) ptrQ <= ptrQ + 1'b1;
  end

  assign slotPtr = ptrQ;
endmodule

// File: rtl/sched_table.sv
module sched_table
  import ctx_sched_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int CTX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  schedStrobe_t     strobe,
  input  logic [PTR_W-1:0] slotPtr,
  input  logic [PTR_W-1:0] wrSlot,
  input  logic [CTX_W-1:0] wrCtx,
  input  logic [PTR_W-1:0] rdSlot,
  output logic [CTX_W-1:0] rdCtx,
  output logic [CTX_W-1:0] ctxId
);
  localparam int SLOTS = 1 << PTR_W;

  logic [CTX_W-1:0] slotQ [SLOTS];
  logic [SLOTS-1:0] slotWe;
  logic [CTX_W-1:0] ctxQ;

  // Per-slot write enables; slot 0 never gets one.
  for (genvar g = 0; g < SLOTS; g++) begin : gWe
    if (g == 0) begin : gPinned
      assign slotWe[g] = 1'b0;
    end else begin : gWritable
      assign slotWe[g] = strobe.tblWrite && (wrSlot == PTR_W'(g));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) slotQ[i] <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++)
        if (slotWe[i]) slotQ[i] <= wrCtx;
    end
  end

  // Output register samples the entry under the current pointer.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctxQ <= '0;
    else       ctxQ <= slotQ[slotPtr];
  end

  assign rdCtx = (rdSlot == '0) ? '0 : slotQ[rdSlot];
  assign ctxId = ctxQ;
endmodule

// File: rtl/ctx_slot_sched.sv
module ctx_slot_sched
  import ctx_sched_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int CTX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             autoMode,
  input  logic             advEn,
  input  logic             stepReq,
  input  logic             wrEn,
  input  logic [PTR_W-1:0] wrSlot,
  input  logic [CTX_W-1:0] wrCtx,
  input  logic [PTR_W-1:0] rdSlot,
  output logic [CTX_W-1:0] rdCtx,
  output logic [CTX_W-1:0] ctxId,
  output logic [PTR_W-1:0] slotPtr
);
  schedStrobe_t strobe;

  sched_ctrl #(.PTR_W(PTR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .autoMode(autoMode), .advEn(advEn),
    .stepReq(stepReq), .wrEn(wrEn), .wrSlot(wrSlot),
    .strobe(strobe), .slotPtr(slotPtr)
  );

  sched_table #(.PTR_W(PTR_W), .CTX_W(CTX_W)) uTable (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slotPtr(slotPtr),
    .wrSlot(wrSlot), .wrCtx(wrCtx), .rdSlot(rdSlot),
    .rdCtx(rdCtx), .ctxId(ctxId)
  );
endmodule

// File: rtl/ctx_slot_sched_chk.sv
module ctx_slot_sched_chk #(
  parameter int PTR_W = 8,
  parameter int CTX_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             autoMode,
  input logic             advEn,
  input logic             stepReq,
  input logic [PTR_W-1:0] rdSlot,
  input logic [CTX_W-1:0] rdCtx,
  input logic [CTX_W-1:0] ctxId,
  input logic [PTR_W-1:0] slotPtr
);
  // R4, R6: automatic step, with wrap.
  a_r4_auto_step: assert property (@(posedge clk) disable iff (!rstN)
    (autoMode && advEn) |=> (slotPtr == PTR_W'($past(slotPtr) + 1'b1)));

  // R4: no advance enable means no movement, whatever stepReq does.
  a_r4_auto_hold: assert property (@(posedge clk) disable iff (!rstN)
    (autoMode && !advEn) |=> $stable(slotPtr));

  // R5: manual step command.
  a_r5_manual_step: assert property (@(posedge clk) disable iff (!rstN)
    (!autoMode && stepReq) |=> (slotPtr == PTR_W'($past(slotPtr) + 1'b1)));

  // R5: without a command the pointer holds, whatever advEn does.
  a_r5_manual_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!autoMode && !stepReq) |=> $stable(slotPtr));

  // R3: slot 0 always reads as context 0.
  a_r3_slot0_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdSlot == '0) |-> (rdCtx == '0));

  // R7: the cycle after the pointer sat on slot 0, context 0 is selected.
  a_r7_slot0_selects_ctx0: assert property (@(posedge clk) disable iff (!rstN)
    ($past(slotPtr) == '0) |-> (ctxId == '0));
endmodule

bind ctx_slot_sched ctx_slot_sched_chk #(.PTR_W(PTR_W), .CTX_W(CTX_W)) uChk (
  .clk(clk), .rstN(rstN), .autoMode(autoMode), .advEn(advEn),
  .stepReq(stepReq), .rdSlot(rdSlot), .rdCtx(rdCtx), .ctxId(ctxId),
  .slotPtr(slotPtr)
);

// File: tb/tb_ctx_slot_sched.sv
module tb_ctx_slot_sched;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 256;

  logic       clk = 1'b0;
  logic       rstN, autoMode, advEn, stepReq, wrEn;
  logic [7:0] wrSlot, rdSlot, slotPtr;
  logic [3:0] wrCtx, rdCtx, ctxId;

  int tests = 0;
  int fails = 0;
  int mTbl [SLOTS];
  int mPtr, mCtx;

  ctx_slot_sched dut (
    .clk(clk), .rstN(rstN), .autoMode(autoMode), .advEn(advEn),
    .stepReq(stepReq), .wrEn(wrEn), .wrSlot(wrSlot), .wrCtx(wrCtx),
    .rdSlot(rdSlot), .rdCtx(rdCtx), .ctxId(ctxId), .slotPtr(slotPtr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkState(string req);
    chk({req, " slotPtr"}, int'(slotPtr), mPtr);
    chk({req, " ctxId"}, int'(ctxId), mCtx);
  endtask

  // One clock: model updates in the same order as the requirements.
  task automatic tick();
    @(posedge clk);
    mCtx = mTbl[mPtr];
    if ((autoMode && advEn) || (!autoMode && stepReq)) mPtr = (mPtr + 1) % SLOTS;
    if (wrEn && wrSlot != 8'd0) mTbl[wrSlot] = int'(wrCtx);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cnt [16];
    int expCnt [16];
    int prevPtr;
    rstN = 1'b0; autoMode = 1'b0; advEn = 1'b0; stepReq = 1'b0;
    wrEn = 1'b0; wrSlot = '0; wrCtx = '0; rdSlot = '0;
    mPtr = 0; mCtx = 0;
    for (int s = 0; s < SLOTS; s++) mTbl[s] = 0;
    repeat (3) @(negedge clk);
    chk("R1 in reset slotPtr", int'(slotPtr), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    checkState("R1");
    for (int s = 0; s < SLOTS; s++) begin
      rdSlot = 8'(s); #1;
      chk("R1 cleared slot", int'(rdCtx), 0);
    end

    // R2/R3: fill every slot in manual mode, slot 0 included
    for (int s = 0; s < SLOTS; s++) begin
      wrEn = 1'b1; wrSlot = 8'(s); wrCtx = 4'((s * 7 + 3) % 16);
      tick();
    end
    wrEn = 1'b0;
    checkState("R5 hold during writes");
    for (int s = 0; s < SLOTS; s++) begin
      rdSlot = 8'(s); #1;
      chk(s == 0 ? "R3 slot0 write ignored" : "R2 readback", int'(rdCtx), mTbl[s]);
    end

    // R5: advEn has no effect in manual mode
    advEn = 1'b1;
    for (int k = 0; k < 4; k++) begin
      tick(); checkState("R5 advEn ignored");
    end
    // R5/R7: single steps with gaps
    for (int k = 0; k < 6; k++) begin
      stepReq = 1'b1; tick(); checkState("R5 step");
      stepReq = 1'b0; tick(); checkState("R7 ctx lag");
    end

    // R4/R6/R7: automatic lap with wrap
    autoMode = 1'b1; advEn = 1'b1;
    for (int k = 0; k < 300; k++) begin
      prevPtr = mPtr;
      tick();
      checkState("R4 auto");
      if (prevPtr == SLOTS - 1) chk("R6 wrap", int'(slotPtr), 0);
    end
    // R4: stepReq ignored in automatic mode
    advEn = 1'b0; stepReq = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick(); checkState("R4 stepReq ignored");
    end
    stepReq = 1'b0;

    // R8: weighted pattern, counted over one full lap
    for (int s = 0; s < SLOTS; s++) begin
      wrEn = 1'b1; wrSlot = 8'(s);
      wrCtx = (s % 4 == 0) ? 4'd5 : (s % 8 == 1) ? 4'd9 : (s % 16 == 3) ? 4'd12 : 4'd0;
      tick();
    end
    wrEn = 1'b0;
    for (int c = 0; c < 16; c++) begin cnt[c] = 0; expCnt[c] = 0; end
    for (int s = 0; s < SLOTS; s++) expCnt[mTbl[s]]++;
    advEn = 1'b1;
    tick();
    for (int k = 0; k < SLOTS; k++) begin
      tick();
      checkState("R7 weighted run");
      cnt[ctxId]++;
    end
    for (int c = 0; c < 16; c++) chk("R8 share per context", cnt[c], expCnt[c]);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule